// File: doc/BRIEF.md
# Parallel Strobe/Handshake Port Controller

This block is a byte-wide parallel I/O controller with one output-only port (port B) and one bidirectional port (port C), plus a strobe pair: an asynchronous strobe input `stb_in` and a strobe/ready output `rdy_out`. A small register interface lets a processor write port B, read the byte latched from port C, write the port C output byte, set per-pin direction for port C and select the operating protocol. Three protocols share the same strobe pair. In simple strobe mode, each write to port B produces a fixed-length pulse on `rdy_out`. In input handshake, `rdy_out` tells a sender that the latch is free. In output handshake, `rdy_out` tells a receiver that port C holds fresh data, and the receiver acknowledges with an edge on `stb_in`.

`stb_in` is brought into the clock domain through a two-stage synchronizer and an edge detector. The selected edge captures the port C pins into the latch in every mode. In the handshake modes, the same edge also releases the ready flop. In output handshake, the synchronized level of `stb_in` can force every port C driver on, like an external bus buffer enable. The ready flop either holds until that edge (interlocked) or drops after a fixed count of clocks (pulsed). Its pin polarity is selectable without disturbing the flop.

The register interface is single-cycle and has no back-pressure: a write lands at the clock edge where `bus_wr` is high, and `bus_rdata` is valid in the same cycle as `bus_rd`. The pin side is level- and edge-driven and has no valid/ready flow control. The handshake protocol itself paces the external device.

Top module: `hs_port_ctrl`

## Requirements
- R1: After reset, `rdy_out` is 0, `pb_out` is 0, every `pc_oe` bit is 0 (input), and the control register (address 3) reads 0x10, so only the true-polarity bit is set.
- R2: Register map: address 0 is port B, address 1 is port C data (read gives the latched byte, write sets the port C output byte), address 2 is port C direction (1 = drive), address 3 is control. Control bits: bit0 handshake enable, bit1 output direction, bit2 pulsed ready, bit3 rising-edge select, bit4 true polarity. Mode: bit0=0 simple; bit0=1 and bit1=0 input handshake; bit0=1 and bit1=1 output handshake.
- R3: In simple mode, a write to port B updates `pb_out` at that clock edge, and the ready flop is active for exactly two clocks from that edge, whatever the pulsed bit says.
- R4: In every mode, the selected edge of `stb_in` (rising if bit3=1, falling if bit3=0) copies `pc_in` into the latched byte at the third rising clock after the pin changes. An edge of the other polarity leaves the latched byte unchanged.
- R5: In input handshake, a read of address 1 sets the ready flop, and a selected `stb_in` edge clears it.
- R6: In output handshake, a write to address 1 puts the byte on `pc_out` and sets the ready flop, and a selected `stb_in` edge clears it.
- R7: In the handshake modes with bit2=0, the ready flop stays set until a selected edge arrives. With bit2=1, it stays set for exactly two clocks.
- R8: `rdy_out` equals the ready flop when bit4=1 and its complement when bit4=0. Changing bit4 leaves the flop unchanged.
- R9: In output handshake, when bit3 XOR the synchronized `stb_in` level is 1, all `pc_oe` bits are 1. Otherwise, and in the other modes, `pc_oe` equals the direction register.
- R10: In the handshake modes, a write to port B updates `pb_out` and leaves `rdy_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pb_out | output | 8 | Port B output byte |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output byte |
| pc_oe | output | 8 | Port C per-pin drive enable |
| stb_in | input | 1 | Asynchronous strobe / acknowledge input |
| rdy_out | output | 1 | Strobe / ready output |

## Verification
The bench sweeps the edge polarity across all three modes. A design that latched on both edges, or on the wrong one, would overwrite the captured byte on the return transition. It also sweeps the pulse and polarity bits in simple mode: a design that honoured the interlock bit there would leave `rdy_out` stuck active. It checks that the interlocked ready survives many idle cycles and a polarity flip, which would catch a design that resets the flop when the polarity changes. It sweeps mode, edge select and strobe level against the output-enable override, which would catch a design that forces drivers outside output handshake or inverts the enable sense.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_PB  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_PC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_DIR = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTL = 2'd3;

  localparam int unsigned CB_HS   = 0;
  localparam int unsigned CB_ODIR = 1;
  localparam int unsigned CB_PLS  = 2;
  localparam int unsigned CB_RISE = 3;
  localparam int unsigned CB_TRUE = 4;

  typedef enum logic [1:0] {
    MODE_SIMPLE = 2'd0,
    MODE_IN_HS  = 2'd1,
    MODE_OUT_HS = 2'd2
  } hs_mode_e;

  function automatic hs_mode_e decode_mode(input logic hs, input logic odir);
    if (!hs)  return MODE_SIMPLE;
    if (odir) return MODE_OUT_HS;
    return MODE_IN_HS;
  endfunction
endpackage

// File: rtl/hs_stb_sync.sv
module hs_stb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic level,
  output logic edge_hit
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign level    = chain[STAGES-1];
  assign edge_hit = rise_sel ? (level & ~prev) : (~level & prev);

  // R4: a detected edge lasts one cycle only
  a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> !edge_hit);
endmodule

// File: rtl/hs_ready_gen.sv
module hs_ready_gen #(
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic pulsed,
  input  logic true_pol,
  output logic flop_q,
  output logic rdy
);
  localparam int unsigned CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flop_q <= 1'b0;
      cnt    <= '0;
    end else if (set_ev) begin
      flop_q <= 1'b1;
      cnt    <= CNT_LOAD;
    end else if (clr_ev) begin
      flop_q <= 1'b0;
    end else if (flop_q && pulsed) begin
      if (cnt == '0) flop_q <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign rdy = true_pol ? flop_q : ~flop_q;

  // R3/R7: a set is visible in the following cycle
  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flop_q);
  // R8: polarity choice alone never moves the flop
  a_r8_pol_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !clr_ev && !pulsed && flop_q) |=> flop_q);
endmodule

// File: rtl/hs_oe_mux.sv
module hs_oe_mux #(
  parameter int unsigned DW = 8
) (
  input  logic          out_mode,
  input  logic          rise_sel,
  input  logic          stb_level,
  input  logic [DW-1:0] dir,
  output logic [DW-1:0] oe
);
  logic force_on;
  assign force_on = out_mode & (rise_sel ^ stb_level);

  for (genvar i = 0; i < DW; i++) begin : g_pin
    assign oe[i] = force_on | dir[i];
  end
endmodule

// File: rtl/hs_port_regs.sv
module hs_port_regs
  import hs_port_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] CTL_RST = DW'(1) << CB_TRUE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     latched,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     pb_q,
  output logic [DW-1:0]     pc_q,
  output logic [DW-1:0]     dir_q,
  output logic [DW-1:0]     ctl_q,
  output logic              pb_wr,
  output logic              pc_wr,
  output logic              pc_rd
);
  assign pb_wr = wr && (addr == ADR_PB);
  assign pc_wr = wr && (addr == ADR_PC);
  assign pc_rd = rd && (addr == ADR_PC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_q  <= '0;
      pc_q  <= '0;
      dir_q <= '0;
      ctl_q <= CTL_RST;
    end else if (wr) begin
      unique case (addr)
        ADR_PB:  pb_q  <= wdata;
        ADR_PC:  pc_q  <= wdata;
        ADR_DIR: dir_q <= wdata;
        default: ctl_q <= wdata;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      ADR_PB:  rdata = pb_q;
      ADR_PC:  rdata = latched;
      ADR_DIR: rdata = dir_q;
      default: rdata = ctl_q;
    endcase
  end
endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl
  import hs_port_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     pb_out,
  input  logic [DW-1:0]     pc_in,
  output logic [DW-1:0]     pc_out,
  output logic [DW-1:0]     pc_oe,
  input  logic              stb_in,
  output logic              rdy_out
);
  logic [DW-1:0] latch_q, dir_q, ctl_q;
  logic          pb_wr, pc_wr, pc_rd;
  logic          stb_lvl, stb_edge;
  logic          set_ev, clr_ev, pulsed, flop_q;
  hs_mode_e      mode;

  hs_port_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .latched(latch_q), .rdata(bus_rdata),
    .pb_q(pb_out), .pc_q(pc_out), .dir_q(dir_q), .ctl_q(ctl_q),
    .pb_wr(pb_wr), .pc_wr(pc_wr), .pc_rd(pc_rd)
  );

  hs_stb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(stb_in), .rise_sel(ctl_q[CB_RISE]),
    .level(stb_lvl), .edge_hit(stb_edge)
  );

  assign mode   = decode_mode(ctl_q[CB_HS], ctl_q[CB_ODIR]);
  assign pulsed = (mode == MODE_SIMPLE) | ctl_q[CB_PLS];
  assign clr_ev = (mode != MODE_SIMPLE) & stb_edge;

  always_comb begin
    unique case (mode)
      MODE_IN_HS:  set_ev = pc_rd;
      MODE_OUT_HS: set_ev = pc_wr;
      default:     set_ev = pb_wr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        latch_q <= '0;
    else if (stb_edge) latch_q <= pc_in;
  end

  hs_ready_gen #(.PULSE_CYC(PULSE_CYC)) u_rdy (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev),
    .pulsed(pulsed), .true_pol(ctl_q[CB_TRUE]), .flop_q(flop_q), .rdy(rdy_out)
  );

  hs_oe_mux #(.DW(DW)) u_oe (
    .out_mode(mode == MODE_OUT_HS), .rise_sel(ctl_q[CB_RISE]),
    .stb_level(stb_lvl), .dir(dir_q), .oe(pc_oe)
  );

  // R4: the latched byte only moves on a detected edge
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_edge |=> $stable(latch_q));
  // R7: interlocked ready survives until an acknowledge edge
  a_r7_interlock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_SIMPLE && !ctl_q[CB_PLS] && flop_q && !stb_edge) |=> flop_q);
  // R9: the enable override drives every pin
  a_r9_oe_force: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OUT_HS && (ctl_q[CB_RISE] ^ stb_lvl)) |-> (&pc_oe));
  // R9: outside output handshake the direction bits rule
  a_r9_oe_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_OUT_HS) |-> (pc_oe == dir_q));
  // R3: simple-mode strobe returns idle after its pulse
  a_r3_simple_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SIMPLE && !set_ev && $past(flop_q) && flop_q) |=> !flop_q);
endmodule

// File: tb/hs_port_ctrl_bench.sv
module hs_port_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, pb_out, pc_in = '0, pc_out, pc_oe;
  logic       stb_in = 1'b0, rdy_out;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  hs_port_ctrl u_hs_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pb_out(pb_out), .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .stb_in(stb_in), .rdy_out(rdy_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic stb(input logic v);
    @(negedge clk); stb_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    logic       idle, prior;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdy", {7'b0, rdy_out}, 8'h00);
    chk("R1 pb", pb_out, 8'h00);
    chk("R1 oe", pc_oe, 8'h00);
    rd(2'd3, v); chk("R1 R2 ctl", v, 8'h10);

    // R3 simple-mode pulse, swept over polarity and pulsed bit
    for (int inv = 0; inv < 2; inv++) begin
      for (int pls = 0; pls < 2; pls++) begin
        wr(2'd3, 8'((inv << 4) | (pls << 2)));
        idle = (inv == 0);
        chk("R8 idle level", {7'b0, rdy_out}, {7'b0, idle});
        wr(2'd0, 8'h30 + 8'(inv * 2 + pls));
        chk("R3 pb value", pb_out, 8'h30 + 8'(inv * 2 + pls));
        chk("R3 cycle1", {7'b0, rdy_out}, {7'b0, ~idle});
        @(negedge clk);
        chk("R3 cycle2", {7'b0, rdy_out}, {7'b0, ~idle});
        @(negedge clk);
        chk("R3 ended", {7'b0, rdy_out}, {7'b0, idle});
      end
    end

    // R4 edge selection across all modes
    for (int rise = 0; rise < 2; rise++) begin
      for (int m = 0; m < 3; m++) begin
        logic [7:0] bval;
        wr(2'd3, 8'h10 | 8'(rise << 3) | (m == 0 ? 8'h00 : m == 1 ? 8'h01 : 8'h03));
        stb(rise ? 1'b0 : 1'b1);
        bval = 8'hA0 + 8'(rise * 16 + m);
        pc_in = bval;
        stb(rise ? 1'b1 : 1'b0);
        rd(2'd1, v); chk("R4 active edge latches", v, bval);
        pc_in = ~bval;
        stb(rise ? 1'b0 : 1'b1);
        rd(2'd1, v); chk("R4 other edge ignored", v, bval);
      end
    end

    // R5/R7 input handshake, interlocked, rising edge, true polarity (stb_in is 0)
    wr(2'd3, 8'h19);
    stb(1'b1); stb(1'b0);
    chk("R5 idle", {7'b0, rdy_out}, 8'h00);
    rd(2'd1, v);
    chk("R5 read asserts", {7'b0, rdy_out}, 8'h01);
    repeat (5) @(negedge clk);
    chk("R7 interlock holds", {7'b0, rdy_out}, 8'h01);
    wr(2'd3, 8'h09);
    chk("R8 inverted pin", {7'b0, rdy_out}, 8'h00);
    wr(2'd3, 8'h19);
    chk("R8 flop kept", {7'b0, rdy_out}, 8'h01);
    stb(1'b1);
    chk("R5 edge clears", {7'b0, rdy_out}, 8'h00);
    stb(1'b0);

    // R7 pulsed input handshake
    wr(2'd3, 8'h1D);
    rd(2'd1, v);
    chk("R7 pulse c1", {7'b0, rdy_out}, 8'h01);
    @(negedge clk);
    chk("R7 pulse c2", {7'b0, rdy_out}, 8'h01);
    @(negedge clk);
    chk("R7 pulse end", {7'b0, rdy_out}, 8'h00);

    // R6 output handshake, interlocked
    wr(2'd3, 8'h1B);
    wr(2'd1, 8'h5A);
    chk("R6 pc_out", pc_out, 8'h5A);
    chk("R6 write asserts", {7'b0, rdy_out}, 8'h01);
    repeat (4) @(negedge clk);
    chk("R7 out interlock holds", {7'b0, rdy_out}, 8'h01);
    stb(1'b1);
    chk("R6 ack clears", {7'b0, rdy_out}, 8'h00);
    stb(1'b0);

    // R9 output-enable override sweep
    wr(2'd2, 8'h0F);
    for (int rise = 0; rise < 2; rise++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        for (int m = 0; m < 3; m++) begin
          wr(2'd3, 8'h10 | 8'(rise << 3) | (m == 0 ? 8'h00 : m == 1 ? 8'h01 : 8'h03));
          stb(lvl[0]);
          chk("R9 oe", pc_oe, (m == 2 && (rise != lvl)) ? 8'hFF : 8'h0F);
        end
      end
    end

    // R10 port B in handshake mode
    wr(2'd3, 8'h19);
    repeat (3) @(negedge clk);
    prior = rdy_out;
    wr(2'd0, 8'h77);
    chk("R10 pb", pb_out, 8'h77);
    chk("R10 rdy c1", {7'b0, rdy_out}, {7'b0, prior});
    repeat (2) @(negedge clk);
    chk("R10 rdy c3", {7'b0, rdy_out}, {7'b0, prior});

    summary();
  end
endmodule